// File: doc/BRIEF.md
# Serial Bus Two-Stage Clock Divider

This block turns the core clock into the timing enables used by a two-wire serial bus controller. A fixed prescaler first divides the core clock by a ratio chosen at elaboration time. The prescaled tick then passes through a programmable power-of-two stage and then a programmable linear stage. The result is a one-cycle sample strobe that runs at ten times the bus bit rate. A phase output toggles after every fifth strobe, which gives a square wave with 50% duty at the bus bit rate.

Software programs a single configuration byte through a write strobe. The linear factor is M+1 and the power-of-two factor is 2^N, so the bus rate is the prescaled rate divided by 10·(M+1)·2^N. Each write restarts the whole chain from zero, so the first strobe after a write arrives one full period later. An enable input stops the chain and holds it cleared.

Top module: `twsi_bus_clkdiv`

## Requirements
- R1: After reset the configuration holds M=0 and N=0, `sample_stb` and `scl_phase` are 0, and no strobe appears while `enable` is low.
- R2: The prescale ratio P is 2·(THP+1) when VARIANT=0 and THP+2 when VARIANT=1. The defaults are VARIANT=1 and THP=3, which gives P=5.
- R3: M is taken from `cfg_wdata[6:3]` and multiplies the strobe period by M+1.
- R4: N is taken from `cfg_wdata[2:0]` and multiplies the strobe period by 2^N.
- R5: `sample_stb` is exactly one cycle wide and repeats every T = P·(M+1)·2^N cycles. The first strobe after a restart appears T-1 cycles after the first counting cycle.
- R6: `scl_phase` toggles in the cycle after every fifth strobe. Ten strobes make one full bus period.
- R7: A cycle with `cfg_we` high produces no strobe. It also clears all counters and sets `scl_phase` to 0, so the next cycle is counting cycle 0 of the new setting.
- R8: While `enable` is low there is no strobe, the counters are held at zero and `scl_phase` is 0. The first cycle with `enable` high is counting cycle 0.
- R9: `cfg_wdata[7]` has no effect on timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run enable for the divider chain |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte: M in bits 6:3, N in bits 2:0 |
| sample_stb | output | 1 | One-cycle oversampling strobe |
| scl_phase | output | 1 | Bus-rate phase, toggles every fifth strobe |

## Verification
The hardest cases to reach are a restart that lands just before a strobe is due, and the longest setting, whose period runs to 10240 cycles. At the ports these look like a strobe that is merely late. The stimulus therefore times configuration writes and enable drops a few cycles before the expected strobe. It then checks that the next strobe comes a full period later and not within the remainder of the old period. Random bytes with N limited to small values cover many periods of mixed M and N. One directed run programs the maximum byte to reach the widest counters.

// File: rtl/twsi_clkdiv_pkg.sv
package twsi_clkdiv_pkg;

  localparam int unsigned STROBES_PER_HALF = 5;

  typedef struct packed {
    logic [3:0] lin_m;
    logic [2:0] pow_n;
  } clk_cfg_t;

  // Prescale ratio for the two supported formulas.
  function automatic int unsigned presc_ratio(input int unsigned variant,
                                              input int unsigned thp);
    if (variant == 0) return 2 * (thp + 1);
    return thp + 2;
  endfunction

  // Split the configuration byte into its fields.
  function automatic clk_cfg_t decode_cfg(input logic [6:0] b);
    clk_cfg_t c;
    c.lin_m = b[6:3];
    c.pow_n = b[2:0];
    return c;
  endfunction

endpackage

// File: rtl/twsi_presc.sv
module twsi_presc #(
  parameter int unsigned RATIO = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic tick
);
  localparam int unsigned CW = (RATIO > 2) ? $clog2(RATIO) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

  logic [CW-1:0] cnt;

  assign tick = !clear && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clear)      cnt <= '0;
    else if (tick)       cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twsi_pow2_div.sv
module twsi_pow2_div #(
  parameter int unsigned NW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick_in,
  input  logic [NW-1:0] pow_n,
  output logic          tick_out
);
  localparam int unsigned PW = (1 << NW) - 1;

  logic [PW-1:0] cnt;
  logic [PW-1:0] limit;

  // 2^n - 1 as a mask of n ones
  assign limit    = ~({PW{1'b1}} << pow_n);
  assign tick_out = tick_in && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (tick_out) cnt <= '0;
    else if (tick_in)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twsi_lin_div.sv
module twsi_lin_div #(
  parameter int unsigned MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          tick_in,
  input  logic [MW-1:0] lin_m,
  output logic          tick_out
);
  logic [MW-1:0] cnt;

  assign tick_out = tick_in && (cnt == lin_m);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (clear)    cnt <= '0;
    else if (tick_out) cnt <= '0;
    else if (tick_in)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twsi_phase.sv
module twsi_phase #(
  parameter int unsigned STEPS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic stb,
  output logic phase
);
  localparam int unsigned SW = (STEPS > 2) ? $clog2(STEPS) : 1;
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  logic [SW-1:0] cnt;
  logic          wrap;

  assign wrap = stb && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (clear) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (wrap) begin
      cnt   <= '0;
      phase <= ~phase;
    end else if (stb) begin
      cnt   <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/twsi_bus_clkdiv.sv
module twsi_bus_clkdiv
  import twsi_clkdiv_pkg::*;
#(
  parameter int unsigned VARIANT = 1,
  parameter int unsigned THP     = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable,
  input  logic       cfg_we,
  input  logic [7:0] cfg_wdata,
  output logic       sample_stb,
  output logic       scl_phase
);
  localparam int unsigned PRE_RATIO = presc_ratio(VARIANT, THP);

  clk_cfg_t cfg_q;
  logic     clear;
  logic     pre_tick;
  logic     pow_tick;
  logic     unused_cfg_hi;

  assign unused_cfg_hi = cfg_wdata[7];
  assign clear         = !enable || cfg_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_we) cfg_q <= decode_cfg(cfg_wdata[6:0]);
  end

  twsi_presc #(.RATIO(PRE_RATIO)) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .tick  (pre_tick)
  );

  twsi_pow2_div #(.NW(3)) u_pow2 (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tick_in  (pre_tick),
    .pow_n    (cfg_q.pow_n),
    .tick_out (pow_tick)
  );

  twsi_lin_div #(.MW(4)) u_lin (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .tick_in  (pow_tick),
    .lin_m    (cfg_q.lin_m),
    .tick_out (sample_stb)
  );

  twsi_phase #(.STEPS(STROBES_PER_HALF)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (clear),
    .stb   (sample_stb),
    .phase (scl_phase)
  );
endmodule

// File: rtl/twsi_clkdiv_checker.sv
module twsi_clkdiv_checker
  import twsi_clkdiv_pkg::*;
#(
  parameter int unsigned VARIANT = 1,
  parameter int unsigned THP     = 3
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic cfg_we,
  input logic sample_stb,
  input logic scl_phase,
  input logic pre_tick,
  input logic pow_tick
);
  localparam int unsigned PRE = presc_ratio(VARIANT, THP);

  int unsigned gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          gap <= 0;
    else if (!enable || cfg_we || pre_tick) gap <= 0;
    else                                 gap <= gap + 1;
  end

  assert_presc_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    pre_tick |-> (gap == PRE - 1));
  assert_presc_not_missed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !cfg_we && gap == PRE - 1) |-> pre_tick);
  assert_pow_on_presc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pow_tick |-> pre_tick);
  assert_stb_on_pow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> pow_tick);
  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);
  assert_phase_only_after_stb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sample_stb && enable && !cfg_we) |=> $stable(scl_phase));
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (!sample_stb && !scl_phase));
  assert_no_stb_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !sample_stb);
  assert_phase_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !scl_phase);
endmodule

bind twsi_bus_clkdiv twsi_clkdiv_checker #(.VARIANT(VARIANT), .THP(THP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .cfg_we     (cfg_we),
  .sample_stb (sample_stb),
  .scl_phase  (scl_phase),
  .pre_tick   (pre_tick),
  .pow_tick   (pow_tick)
);

// File: tb/test_twsi_bus_clkdiv.sv
module test_twsi_bus_clkdiv;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       sample_stb;
  logic       scl_phase;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  twsi_bus_clkdiv i_twsi_bus_clkdiv (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .sample_stb(sample_stb), .scl_phase(scl_phase)
  );

  // Default parameters: VARIANT=1, THP=3 -> prescale 3+2
  function automatic int exp_period(input logic [7:0] b);
    int m_fac = int'(b[6:3]) + 1;
    int n_fac = 1 << b[2:0];
    return (3 + 2) * m_fac * n_fac;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Leaves the bench at the negedge of counting cycle 0.
  task automatic apply_cfg(input logic [7:0] b);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Cycles from the current negedge (cycle 0) to the next strobe.
  task automatic wait_strobe(output int n, input int lim);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sample_stb && n < lim);
  endtask

  task automatic period_test(input logic [7:0] b, input string req);
    int t = exp_period(b);
    int n;
    apply_cfg(b);
    wait_strobe(n, t + 8);
    chk(n == t - 1, req, n, t - 1);
    wait_strobe(n, t + 8);
    chk(n == t, req, n, t);
  endtask

  task automatic phase_test(input logic [7:0] b);
    int t = exp_period(b);
    int strobes = 0;
    int tog1 = -1;
    int tog2 = -1;
    logic prev;
    apply_cfg(b);
    prev = scl_phase;
    chk(scl_phase == 1'b0, "R7 phase cleared", int'(scl_phase), 0);
    for (int k = 1; k <= 10 * t; k++) begin
      @(negedge clk);
      if (scl_phase != prev) begin
        if (tog1 < 0) tog1 = k; else if (tog2 < 0) tog2 = k;
      end
      prev = scl_phase;
      if (k < 10 * t && sample_stb) strobes++;
    end
    chk(tog1 == 5 * t, "R6 first toggle", tog1, 5 * t);
    chk(tog2 == 10 * t, "R6 second toggle", tog2, 10 * t);
    chk(strobes == 10, "R6 strobes per bus period", strobes, 10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1..all: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int n;
    int cnt;
    int t;
    logic [7:0] b;
    void'($urandom(32'h5eed_1234));

    // R1: reset state and idle with enable low
    repeat (3) @(negedge clk);
    chk(sample_stb == 1'b0, "R1 stb in reset", int'(sample_stb), 0);
    chk(scl_phase == 1'b0, "R1 phase in reset", int'(scl_phase), 0);
    rst_n = 1'b1;
    cnt = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (sample_stb) cnt++;
    end
    chk(cnt == 0, "R1 no strobe while disabled", cnt, 0);

    // R1/R2: reset configuration M=0,N=0 -> period equals prescale ratio 5
    enable = 1'b1;
    wait_strobe(n, 20);
    chk(n == 4, "R1 R2 reset config first strobe", n, 4);
    wait_strobe(n, 20);
    chk(n == 5, "R2 prescale period", n, 5);

    // R3, R4: directed field checks
    period_test(8'h18, "R3 M=3");
    period_test(8'h03, "R4 N=3");
    period_test(8'h2A, "R3 R4 M=5 N=2");

    // R9: top bit ignored
    period_test(8'h89, "R9 bit7 set");
    period_test(8'h09, "R9 bit7 clear");

    // R6: phase toggling
    phase_test(8'h00);
    phase_test(8'h0B);

    // R7: rewrite just before a strobe is due
    t = exp_period(8'h11);
    apply_cfg(8'h11);
    repeat (t - 3) @(negedge clk);
    apply_cfg(8'h08);
    wait_strobe(n, 100);
    chk(n == exp_period(8'h08) - 1, "R7 restart on write", n, exp_period(8'h08) - 1);

    // R8: enable drop just before a strobe
    t = exp_period(8'h12);
    apply_cfg(8'h12);
    repeat (t - 3) @(negedge clk);
    enable = 1'b0;
    cnt = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (sample_stb) cnt++;
    end
    chk(cnt == 0, "R8 no strobe disabled", cnt, 0);
    chk(scl_phase == 1'b0, "R8 phase held low", int'(scl_phase), 0);
    enable = 1'b1;
    wait_strobe(n, t + 8);
    chk(n == t - 1, "R8 restart from zero after enable", n, t - 1);

    // R5: maximum setting
    t = exp_period(8'h7F);
    apply_cfg(8'h7F);
    wait_strobe(n, t + 8);
    chk(n == t - 1, "R5 R3 R4 maximum period", n, t - 1);
    @(negedge clk);
    chk(sample_stb == 1'b0, "R5 one cycle wide", int'(sample_stb), 0);

    // Random settings with small N
    for (int i = 0; i < 12; i++) begin
      b = 8'($urandom);
      b[2:0] = 3'($urandom % 5);
      period_test(b, "R5 random period");
      if (i % 4 == 0) phase_test(b & 8'h1B);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule